// File: doc/BRIEF.md
# Memory Bus Cycle Strobe Sequencer

This block steps one memory bus transaction at a time through four clock states (T1, T2, T3, T4), with any number of wait states placed between T2 and T3. From that state sequence it derives three staggered active-low timing strobes and a memory write strobe. Each strobe changes on a clock edge. The row strobe falls first, the address-mux strobe falls next and the column strobe falls last. All three rise together when T4 ends. They can drive a DRAM's row strobe, its address multiplexer select and its column strobe directly. Read, write and refresh transactions all produce the timing strobes. Only a write produces the write strobe.

A requester presents a request with a kind code while the sequencer is idle. The sequencer reports that a transaction is running and drives an output enable, which stands in for the strobe drivers leaving high impedance. It issues a single-cycle completion pulse once T4 has ended. The raw active-low reset is qualified internally, so a glitch or a short low pulse cannot disturb a running transaction.

Top module: `memcyc_strobe_seq`

## Requirements
- R1: `tref_r_n` goes low on the clock edge that ends T1 and stays low until the edge that ends T4, for every transaction kind.
- R2: `tref_a_n` goes low on the edge that ends T2, stays low through all wait states, and rises on the edge that ends T4, for every kind.
- R3: `tref_c_n` goes low on the edge that ends T3 and rises on the edge that ends T4, so it is low for exactly one cycle, for every kind.
- R4: `mwr_n` is low over the same interval as `tref_a_n`, but only when the kind is write (`req_kind` = 2'b01). For read (2'b00), refresh (2'b10) and the unused code 2'b11, `mwr_n` stays high for the whole transaction.
- R5: `wait_n` is sampled on the edge that ends T2 and on the edge that ends each wait state. Each low sample adds one wait state, and during it all strobes keep their values.
- R6: when `rst_n` is held low on RST_MIN_CYC (default 5) or more consecutive rising edges, the sequencer goes idle on the following edge. Any running transaction is abandoned and no `done` pulse is issued for it.
- R7: a `rst_n` low pulse that spans fewer than RST_MIN_CYC consecutive edges has no effect on a running transaction. The transaction's strobes and its `done` pulse keep their normal timing.
- R8: when idle, all four strobes are high and `bus_oe` and `busy` are low. From T1 through T4, `bus_oe` and `busy` are high.
- R9: `done` is high for exactly one cycle, namely the cycle that follows T4.
- R10: a request is accepted only in the idle state, and T1 follows in the next cycle. A `req_valid` that is still high while a transaction runs, including in T4, starts nothing.
- R11: a low `wait_n` sampled in T1, T3 or T4 adds no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Raw active-low reset, qualified internally by length |
| req_valid | input | 1 | Transaction request, sampled while idle |
| req_kind | input | 2 | 00 read, 01 write, 10 refresh, 11 treated as read |
| wait_n | input | 1 | Active-low wait request |
| mwr_n | output | 1 | Active-low memory write strobe |
| tref_r_n | output | 1 | Active-low row timing strobe |
| tref_a_n | output | 1 | Active-low address-mux timing strobe |
| tref_c_n | output | 1 | Active-low column timing strobe |
| bus_oe | output | 1 | Strobe drivers enabled (low means high impedance) |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse after T4 |

## Verification
Each of the three kinds, plus the unused code, runs with no wait states. The write strobe is the only output that separates them, so these runs show that the kind is latched and decoded correctly. Runs with one to four low `wait_n` samples check that the wait state lands between the mux and column edges and that strobes hold during it. Runs with `wait_n` pulled low in T1 and T3 show that it is sampled only in T2 and in wait states. A request held high through a whole transaction shows that nothing is accepted outside idle. A three-cycle reset pulse during a wait state, set against a seven-cycle pulse that abandons a write, tells the length qualifier apart from a plain reset.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;

   localparam int KIND_W = 2;

   localparam logic [KIND_W-1:0] KIND_RD = 2'b00;
   localparam logic [KIND_W-1:0] KIND_WR = 2'b01;
   localparam logic [KIND_W-1:0] KIND_RF = 2'b10;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_TW   = 3'd3,
      ST_T3   = 3'd4,
      ST_T4   = 3'd5
   } cyc_state_t;

   typedef struct packed {
      logic wr_n;
      logic row_n;
      logic mux_n;
      logic col_n;
      logic oe;
   } strobe_t;

   // Strobe levels that hold throughout a given bus state.
   function automatic strobe_t strobe_of(cyc_state_t s, logic [KIND_W-1:0] k);
      strobe_t o;
      logic    row_on;
      logic    mux_on;
      row_on  = (s == ST_T2) || (s == ST_TW) || (s == ST_T3) || (s == ST_T4);
      mux_on  = (s == ST_TW) || (s == ST_T3) || (s == ST_T4);
      o.row_n = !row_on;
      o.mux_n = !mux_on;
      o.col_n = !(s == ST_T4);
      o.wr_n  = !(mux_on && (k == KIND_WR));
      o.oe    = (s != ST_IDLE);
      return o;
   endfunction

endpackage

// File: rtl/memcyc_rst_qual.sv
module memcyc_rst_qual #(
   parameter int RST_MIN_CYC = 5
) (
   input  logic clk,
   input  logic rst_raw_n,
   output logic rst_act
);
   localparam int CW = $clog2(RST_MIN_CYC + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(RST_MIN_CYC);

   logic [CW-1:0] low_cnt;

   // Counts consecutive low samples, saturating once the minimum is met.
   always_ff @(posedge clk) begin
      if (rst_raw_n)
         low_cnt <= '0;
      else if (low_cnt != CNT_TOP)
         low_cnt <= low_cnt + 1'b1;
   end

   assign rst_act = (low_cnt == CNT_TOP);

endmodule

// File: rtl/memcyc_fsm.sv
module memcyc_fsm
   import memcyc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_act,
   input  logic              req_valid,
   input  logic [KIND_W-1:0] req_kind,
   input  logic              wait_n,
   output cyc_state_t        st,
   output cyc_state_t        st_nxt,
   output logic [KIND_W-1:0] kind_q,
   output logic              done
);

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_IDLE: if (req_valid) st_nxt = ST_T1;
         ST_T1:   st_nxt = ST_T2;
         ST_T2,
         ST_TW:   st_nxt = wait_n ? ST_T3 : ST_TW;
         ST_T3:   st_nxt = ST_T4;
         ST_T4:   st_nxt = ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst_act) begin
         st     <= ST_IDLE;
         kind_q <= KIND_RD;
         done   <= 1'b0;
      end else begin
         st   <= st_nxt;
         done <= (st == ST_T4);
         if (st == ST_IDLE && req_valid)
            kind_q <= req_kind;
      end
   end

endmodule

// File: rtl/memcyc_strobe_gen.sv
module memcyc_strobe_gen
   import memcyc_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_act,
   input  cyc_state_t        st,
   input  cyc_state_t        st_nxt,
   input  logic [KIND_W-1:0] kind_q,
   input  logic              req_valid,
   input  logic [KIND_W-1:0] req_kind,
   output strobe_t           stb
);

   generate
      if (REG_OUT) begin : g_reg
         // Flops loaded from the next state: same edge timing, no decode glitches.
         logic [KIND_W-1:0] kind_n;
         strobe_t           stb_q;
         assign kind_n = (st == ST_IDLE && req_valid) ? req_kind : kind_q;
         always_ff @(posedge clk) begin
            if (rst_act)
               stb_q <= strobe_of(ST_IDLE, KIND_RD);
            else
               stb_q <= strobe_of(st_nxt, kind_n);
         end
         assign stb = stb_q;
      end else begin : g_dec
         logic unused_in;
         assign unused_in = clk ^ rst_act ^ req_valid ^ (^req_kind) ^ (^st_nxt);
         assign stb = strobe_of(st, kind_q);
      end
   endgenerate

endmodule

// File: rtl/memcyc_strobe_seq.sv
module memcyc_strobe_seq
   import memcyc_pkg::*;
#(
   parameter int RST_MIN_CYC = 5,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_kind,
   input  logic       wait_n,
   output logic       mwr_n,
   output logic       tref_r_n,
   output logic       tref_a_n,
   output logic       tref_c_n,
   output logic       bus_oe,
   output logic       busy,
   output logic       done
);

   if (RST_MIN_CYC < 1) begin : g_bad_rst
      $error("RST_MIN_CYC must be at least 1");
   end
   if (KIND_W != 2) begin : g_bad_kind
      $error("kind field must be two bits wide");
   end

   logic              rst_act;
   cyc_state_t        st;
   cyc_state_t        st_nxt;
   logic [KIND_W-1:0] kind_q;
   strobe_t           stb;

   memcyc_rst_qual #(.RST_MIN_CYC(RST_MIN_CYC)) u_rst (
      .clk       (clk),
      .rst_raw_n (rst_n),
      .rst_act   (rst_act)
   );

   memcyc_fsm u_fsm (
      .clk       (clk),
      .rst_act   (rst_act),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .wait_n    (wait_n),
      .st        (st),
      .st_nxt    (st_nxt),
      .kind_q    (kind_q),
      .done      (done)
   );

   memcyc_strobe_gen #(.REG_OUT(REG_OUT)) u_stb (
      .clk       (clk),
      .rst_act   (rst_act),
      .st        (st),
      .st_nxt    (st_nxt),
      .kind_q    (kind_q),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .stb       (stb)
   );

   assign mwr_n    = stb.wr_n;
   assign tref_r_n = stb.row_n;
   assign tref_a_n = stb.mux_n;
   assign tref_c_n = stb.col_n;
   assign bus_oe   = stb.oe;
   assign busy     = (st != ST_IDLE);

endmodule

// File: rtl/memcyc_strobe_seq_chk.sv
module memcyc_strobe_seq_chk
   import memcyc_pkg::*;
(
   input logic       clk,
   input logic       rst_act,
   input cyc_state_t st,
   input logic       req_valid,
   input logic       wait_n,
   input logic       mwr_n,
   input logic       tref_r_n,
   input logic       tref_a_n,
   input logic       tref_c_n,
   input logic       bus_oe,
   input logic       done
);

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= armed | rst_act;

   p_row_from_t1_r1: assert property (@(posedge clk) disable iff (rst_act || !armed)
      $fell(tref_r_n) |-> $past(bus_oe));

   p_mux_under_row_r2: assert property (@(posedge clk) disable iff (rst_act || !armed)
      !tref_a_n |-> !tref_r_n);

   p_col_under_mux_r3: assert property (@(posedge clk) disable iff (rst_act || !armed)
      !tref_c_n |-> !tref_a_n);

   p_col_one_cycle_r3: assert property (@(posedge clk) disable iff (rst_act || !armed)
      !tref_c_n |=> tref_c_n);

   p_wr_under_mux_r4: assert property (@(posedge clk) disable iff (rst_act || !armed)
      !mwr_n |-> !tref_a_n);

   p_wait_holds_r5: assert property (@(posedge clk) disable iff (rst_act || !armed)
      ((st == ST_T2 || st == ST_TW) && !wait_n) |=> (st == ST_TW && tref_c_n && !tref_a_n));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst_act || !armed)
      !bus_oe |-> (mwr_n && tref_r_n && tref_a_n && tref_c_n));

   p_done_single_r9: assert property (@(posedge clk) disable iff (rst_act || !armed)
      done |=> !done);

   p_accept_idle_r10: assert property (@(posedge clk) disable iff (rst_act || !armed)
      (st == ST_IDLE && req_valid) |=> (st == ST_T1));

   p_t4_ends_r10: assert property (@(posedge clk) disable iff (rst_act || !armed)
      (st == ST_T4) |=> (st == ST_IDLE && done));

   p_t1_no_wait_r11: assert property (@(posedge clk) disable iff (rst_act || !armed)
      (st == ST_T1) |=> (st == ST_T2));

endmodule

bind memcyc_strobe_seq memcyc_strobe_seq_chk u_chk (
   .clk       (clk),
   .rst_act   (rst_act),
   .st        (st),
   .req_valid (req_valid),
   .wait_n    (wait_n),
   .mwr_n     (mwr_n),
   .tref_r_n  (tref_r_n),
   .tref_a_n  (tref_a_n),
   .tref_c_n  (tref_c_n),
   .bus_oe    (bus_oe),
   .done      (done)
);

// File: tb/tb_memcyc_strobe_seq.sv
module tb_memcyc_strobe_seq;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'b00;
   logic       wait_n = 1'b1;
   logic       mwr_n, tref_r_n, tref_a_n, tref_c_n, bus_oe, busy, done;

   memcyc_strobe_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .wait_n(wait_n), .mwr_n(mwr_n), .tref_r_n(tref_r_n), .tref_a_n(tref_a_n),
      .tref_c_n(tref_c_n), .bus_oe(bus_oe), .busy(busy), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Vector bits: {mwr_n, row_n, mux_n, col_n, oe, busy, done}
   localparam logic [6:0] V_IDLE  = 7'b1111_000;
   localparam logic [6:0] V_IDONE = 7'b1111_001;
   localparam logic [6:0] V_T1    = 7'b1111_110;
   localparam logic [6:0] V_T2    = 7'b1011_110;

   logic [6:0] exp_q[$];
   string      ctx = "reset";
   bit         mon_en = 1'b0;
   bit         finished = 1'b0;
   int         n_vec = 0;
   int         n_bad = 0;
   string      fld_tag [7] = '{"R9", "R8", "R8", "R3", "R2", "R1", "R4"};

   function automatic logic [6:0] now_vec();
      return {mwr_n, tref_r_n, tref_a_n, tref_c_n, bus_oe, busy, done};
   endfunction

   function automatic logic [6:0] v_mid(bit wr);
      return {!wr, 6'b00_1110};
   endfunction

   function automatic logic [6:0] v_t4(bit wr);
      return {!wr, 6'b00_0110};
   endfunction

   task automatic compare(logic [6:0] got, logic [6:0] exp);
      string tag;
      n_vec++;
      if (got !== exp) begin
         tag = "R8";
         for (int b = 0; b < 7; b++) if (got[b] !== exp[b]) tag = fld_tag[b];
         n_bad++;
         $display("FAIL %s (%s) t=%0t got %b expected %b", tag, ctx, $time, got, exp);
      end
   endtask

   // Monitor: pops one expected vector per clock, idle when the queue is empty.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_en) begin
            logic [6:0] e;
            e = (exp_q.size() != 0) ? exp_q.pop_front() : V_IDLE;
            compare(now_vec(), e);
         end
      end
   end

   // Driver: one transaction, pushing the vector expected after each edge.
   task automatic txn(logic [1:0] k, int nw, bit hold_req, bit stray_wait, bit short_rst);
      bit wr;
      wr = (k == 2'b01);
      @(negedge clk); req_valid = 1'b1; req_kind = k; exp_q.push_back(V_T1);
      @(negedge clk); if (!hold_req) req_valid = 1'b0;
      if (stray_wait) wait_n = 1'b0;                       // R11: sampled in T1
      exp_q.push_back(V_T2);
      for (int i = 0; i < nw; i++) begin
         @(negedge clk); wait_n = 1'b0;
         if (short_rst) rst_n = (i >= 3);                  // R7: three low edges
         exp_q.push_back(v_mid(wr));
      end
      @(negedge clk); wait_n = 1'b1; rst_n = 1'b1; exp_q.push_back(v_mid(wr));
      @(negedge clk); if (stray_wait) wait_n = 1'b0;       // R11: sampled in T3
      exp_q.push_back(v_t4(wr));
      @(negedge clk); wait_n = 1'b1; exp_q.push_back(V_IDONE);
      @(negedge clk); req_valid = 1'b0;                    // R10: held req ignored in T4
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (8) @(negedge clk);
      ctx = "R6 R8 reset state";
      compare(now_vec(), V_IDLE);
      rst_n = 1'b1;
      @(negedge clk);
      mon_en = 1'b1;

      ctx = "R1 R2 R3 R8 R9 read";      txn(2'b00, 0, 0, 0, 0);
      ctx = "R4 write";                 txn(2'b01, 0, 0, 0, 0);
      ctx = "R4 refresh";               txn(2'b10, 0, 0, 0, 0);
      ctx = "R4 unused code as read";   txn(2'b11, 0, 0, 0, 0);
      ctx = "R5 write three waits";     txn(2'b01, 3, 0, 0, 0);
      ctx = "R5 read one wait";         txn(2'b00, 1, 0, 0, 0);
      ctx = "R10 request held";         txn(2'b01, 0, 1, 0, 0);
      ctx = "R11 stray wait";           txn(2'b01, 2, 0, 1, 0);
      ctx = "R7 short reset";           txn(2'b00, 4, 0, 0, 1);
      @(negedge clk);

      // R6: a long reset abandons a write held in wait states, with no done.
      mon_en = 1'b0;
      ctx = "R6 long reset abort";
      req_valid = 1'b1; req_kind = 2'b01;
      @(negedge clk); req_valid = 1'b0; wait_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      compare(now_vec(), v_mid(1'b1));
      rst_n = 1'b0;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         n_vec++;
         if (done !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 done during reset got %b expected 0", done);
         end
      end
      compare(now_vec(), V_IDLE);
      rst_n = 1'b1; wait_n = 1'b1;
      @(negedge clk);
      compare(now_vec(), V_IDLE);
      mon_en = 1'b1;
      ctx = "R6 recovery read";         txn(2'b00, 0, 0, 0, 0);
      repeat (2) @(negedge clk);

      summary();
      $finish;
   end

endmodule